// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

This block gathers a set of interrupt request lines into one interrupt output for a processor. Each line is captured in a pending register, either on its rising edge or by tracking its level, as chosen by a configuration bit. A per-line mask keeps a pending line from reaching the output. A separate in-service register records which levels the processor is currently handling. A fixed priority resolver picks the winner, with line 0 highest and the last line lowest. The output is raised only when the best unmasked pending line outranks every level in service.

The processor answers the output with a one-cycle acknowledge pulse. This moves the winning line from pending to in-service and presents its index on the vector output from the next cycle on. When the handler finishes, software writes the end-of-interrupt register, which retires the highest-priority in-service level. A small register port reads back the pending, mask, in-service and configuration registers and writes the mask and configuration.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, in-service and mask registers read 0, the configuration reads 0 (edge mode), `int_req` is 0 and `vector` is 0.
- R2: In edge mode (configuration bit 0 = 0) a 0-to-1 change on a line sets its pending bit at the next clock edge. A line held high after its bit was acknowledged does not set the bit again.
- R3: In level mode (configuration bit 0 = 1) each pending bit equals the value its line had one clock earlier, and acknowledge does not hold it clear.
- R4: A pending line whose mask bit is 1 keeps its pending bit but does not raise `int_req`. Clearing the mask bit lets it raise `int_req`.
- R5: Priority is fixed: among unmasked pending lines the lowest index wins.
- R6: `int_req` is 1 only when the winning index is lower than the lowest set in-service index, or when no in-service bit is set.
- R7: An `ack` pulse while `int_req` is 1 sets the winner's in-service bit, clears its pending bit in edge mode, and drives its index on `vector` from the next cycle until the next granted acknowledge.
- R8: An `ack` pulse while `int_req` is 0 changes neither the registers nor `vector`.
- R9: A write to address 2 is an end-of-interrupt. It clears only the lowest-index set in-service bit, and the written data is ignored.
- R10: `cfg_rdata` shows the selected register without delay: address 0 for pending, 1 for the mask (writable), 2 for in-service, and 3 for the configuration, with the mode in bit 0 (writable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | N_LINES | Interrupt request lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | N_LINES | Register write data |
| cfg_rdata | output | N_LINES | Register read data for `cfg_addr` |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt output |
| vector | output | $clog2(N_LINES) | Index of the last granted line |

## Verification
A wrong pending or in-service bit shows at once on `int_req`. It raises the output under a higher-priority service level, or holds it low when it should be high. The next read of address 0 or 2 exposes the same fault in the same cycle. A wrong winner shows on `vector` one cycle after the acknowledge. A wrong end-of-interrupt choice shows as a suppressed or released request after the next EOI write. The bench walks through nested service, masking, both trigger modes and simultaneous requests to expose each of these.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        REG_PEND = 2'd0,
        REG_MASK = 2'd1,
        REG_SERV = 2'd2,
        REG_CFG  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pic_first_set.sv
module pic_first_set #(
    parameter int N_BITS = 8,
    localparam int IW = $clog2(N_BITS)
) (
    input  logic [N_BITS-1:0] bits_in,
    output logic              found,
    output logic [IW-1:0]     idx
);
    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_BITS - 1; i >= 0; i--) begin
            if (bits_in[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_req_next.sv
module pic_req_next #(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0] lines_now,
    input  logic [N_LINES-1:0] lines_prev,
    input  logic [N_LINES-1:0] pend_cur,
    input  logic [N_LINES-1:0] grant_clr,
    input  logic               level_mode,
    output logic [N_LINES-1:0] pend_nxt
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic rise;
        assign rise = lines_now[g] & ~lines_prev[g];
        assign pend_nxt[g] = level_mode ? lines_now[g]
                                        : ((pend_cur[g] & ~grant_clr[g]) | rise);
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [N_LINES-1:0] cfg_wdata,
    output logic [N_LINES-1:0] cfg_rdata,
    input  logic               ack,
    output logic               int_req,
    output logic [IW-1:0]      vector
);
    typedef struct packed {
        logic [N_LINES-1:0] pend;
        logic [N_LINES-1:0] serv;
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] prev;
        logic               level;
        logic [IW-1:0]      vec;
    } state_t;

    state_t st_d, st_q;

    logic [N_LINES-1:0] pend_q, serv_q, mask_q;
    logic               level_q;
    assign pend_q  = st_q.pend;
    assign serv_q  = st_q.serv;
    assign mask_q  = st_q.mask;
    assign level_q = st_q.level;

    logic [N_LINES-1:0] live_req;
    logic               live_any, serv_any;
    logic [IW-1:0]      live_idx, serv_idx;
    logic               grant, eoi;
    logic [N_LINES-1:0] grant_oh, eoi_oh, pend_nxt;

    assign live_req = pend_q & ~mask_q;

    pic_first_set #(.N_BITS(N_LINES)) u_live (
        .bits_in(live_req), .found(live_any), .idx(live_idx)
    );
    pic_first_set #(.N_BITS(N_LINES)) u_serv (
        .bits_in(serv_q), .found(serv_any), .idx(serv_idx)
    );

    assign int_req  = live_any && (!serv_any || (live_idx < serv_idx));
    assign grant    = ack && int_req;
    assign grant_oh = grant ? (N_LINES'(1) << live_idx) : '0;
    assign eoi      = cfg_we && (cfg_addr == REG_SERV);
    assign eoi_oh   = (eoi && serv_any) ? (N_LINES'(1) << serv_idx) : '0;

    pic_req_next #(.N_LINES(N_LINES)) u_req (
        .lines_now (irq_lines),
        .lines_prev(st_q.prev),
        .pend_cur  (pend_q),
        .grant_clr (grant_oh),
        .level_mode(level_q),
        .pend_nxt  (pend_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nxt;
        st_d.prev = irq_lines;
        st_d.serv = (serv_q & ~eoi_oh) | grant_oh;
        if (grant) begin
            st_d.vec = live_idx;
        end
        if (cfg_we && (cfg_addr == REG_MASK)) begin
            st_d.mask = cfg_wdata;
        end
        if (cfg_we && (cfg_addr == REG_CFG)) begin
            st_d.level = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            REG_PEND: cfg_rdata = pend_q;
            REG_MASK: cfg_rdata = mask_q;
            REG_SERV: cfg_rdata = serv_q;
            default:  cfg_rdata = {{(N_LINES-1){1'b0}}, level_q};
        endcase
    end

    assign vector = st_q.vec;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_LINES = 8,
    localparam int IW = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_lines,
    input logic               cfg_we,
    input logic [1:0]         cfg_addr,
    input logic               ack,
    input logic               int_req,
    input logic [IW-1:0]      vector,
    input logic [N_LINES-1:0] pend_q,
    input logic [N_LINES-1:0] serv_q,
    input logic [N_LINES-1:0] mask_q,
    input logic               level_q
);
    logic eoi_w;
    assign eoi_w = cfg_we && (cfg_addr == 2'd2);

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((pend_q & ~mask_q) != '0));

    p_grant_serv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_req) |=> serv_q[vector]);

    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && int_req) |=> $stable(vector));

    p_noack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_req && !cfg_we) |=> (serv_q == $past(serv_q)));

    p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_w && !(ack && int_req) && (serv_q != '0))
        |=> ($countones(serv_q) + 1 == $past($countones(serv_q))));

    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q && $past(level_q)) |-> (pend_q == $past(irq_lines)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_lines(irq_lines),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .ack      (ack),
    .int_req  (int_req),
    .vector   (vector),
    .pend_q   (pend_q),
    .serv_q   (serv_q),
    .mask_q   (mask_q),
    .level_q  (level_q)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [N-1:0]  cfg_wdata = '0;
    logic [N-1:0]  cfg_rdata;
    logic          ack = 1'b0;
    logic          int_req;
    logic [IW-1:0] vector;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [IW-1:0] idx;
        string         tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    prio_irq_ctrl #(.N_LINES(N)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ack(ack), .int_req(int_req), .vector(vector)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        cfg_addr = a;
        #1;
        chk(tag, int'(cfg_rdata), exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // driver: pulse ack, push expected vector when a grant is expected
    task automatic do_ack(input bit granted, input int idx, input string tag);
        exp_t e;
        if (granted) begin
            e.idx = IW'(idx);
            e.tag = tag;
            exp_q.push_back(e);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // monitor: after each acknowledge edge, compare vector with the queue head
    initial begin
        forever begin
            @(posedge clk);
            if (ack === 1'b1 && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                @(negedge clk);
                #1;
                chk(e.tag, int'(vector), int'(e.idx));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 int_req", int'(int_req), 0);
        chk("R1 vector", int'(vector), 0);
        rd(2'd0, 0, "R1 pending");
        rd(2'd1, 0, "R1 mask");
        rd(2'd2, 0, "R1 in-service");
        rd(2'd3, 0, "R1 config");

        // R2 edge capture
        irq_lines = 8'h20;
        tick();
        rd(2'd0, 'h20, "R2 pending after rise");
        chk("R6 int_req idle service", int'(int_req), 1);
        do_ack(1, 5, "R7 vector line5");
        tick();
        rd(2'd2, 'h20, "R7 in-service line5");
        rd(2'd0, 'h00, "R2 held line no re-set");
        chk("R6 int_req blocked by own service", int'(int_req), 0);

        // R6 nesting
        irq_lines = 8'h60;
        tick();
        rd(2'd0, 'h40, "R6 pending line6");
        chk("R6 lower priority blocked", int'(int_req), 0);
        irq_lines = 8'h64;
        tick();
        rd(2'd0, 'h44, "R2 pending lines 2 and 6");
        chk("R6 higher priority passes", int'(int_req), 1);
        do_ack(1, 2, "R5 vector line2");
        tick();
        rd(2'd2, 'h24, "R7 nested in-service");
        chk("R6 blocked under line2", int'(int_req), 0);

        // R8 acknowledge without request
        do_ack(0, 0, "");
        tick();
        rd(2'd2, 'h24, "R8 in-service unchanged");
        rd(2'd0, 'h40, "R8 pending unchanged");
        chk("R8 vector unchanged", int'(vector), 2);

        // R9 end of interrupt
        wr(2'd2, 8'hFF);
        rd(2'd2, 'h20, "R9 eoi clears line2 only");
        chk("R6 still blocked by line5", int'(int_req), 0);
        wr(2'd2, 8'h00);
        rd(2'd2, 'h00, "R9 eoi clears line5");
        chk("R6 line6 released", int'(int_req), 1);
        do_ack(1, 6, "R7 vector line6");
        wr(2'd2, 8'h00);
        rd(2'd2, 'h00, "R9 eoi line6");
        irq_lines = 8'h00;
        tick();

        // R4 mask
        wr(2'd1, 8'h08);
        rd(2'd1, 'h08, "R10 mask readback");
        irq_lines = 8'h08;
        tick();
        irq_lines = 8'h00;
        tick();
        rd(2'd0, 'h08, "R4 masked line stays pending");
        chk("R4 masked no int_req", int'(int_req), 0);
        wr(2'd1, 8'h00);
        chk("R4 unmasked int_req", int'(int_req), 1);
        do_ack(1, 3, "R4 vector line3");
        wr(2'd2, 8'h00);

        // R3 level mode
        wr(2'd3, 8'h01);
        rd(2'd3, 1, "R10 config readback");
        irq_lines = 8'h81;
        tick();
        rd(2'd0, 'h81, "R3 pending follows lines");
        irq_lines = 8'h80;
        tick();
        rd(2'd0, 'h80, "R3 pending drops with line");
        do_ack(1, 7, "R3 vector line7");
        tick();
        rd(2'd0, 'h80, "R3 ack does not clear level");
        rd(2'd2, 'h80, "R7 in-service line7");
        irq_lines = 8'h00;
        tick();
        rd(2'd0, 'h00, "R3 pending clears with line");
        wr(2'd2, 8'h00);

        // R5 simultaneous edges
        wr(2'd3, 8'h00);
        irq_lines = 8'h90;
        tick();
        rd(2'd0, 'h90, "R5 both pending");
        do_ack(1, 4, "R5 vector line4 first");
        rd(2'd0, 'h80, "R7 line4 pending cleared");
        chk("R6 line7 blocked", int'(int_req), 0);
        wr(2'd2, 8'h00);
        chk("R9 line7 released", int'(int_req), 1);
        do_ack(1, 7, "R5 vector line7 second");
        tick();
        rd(2'd2, 'h80, "R9 in-service line7");
        tick();

        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 queue: actual %0d left expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule